// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one whole NAND flash operation each time software launches it. Software first loads four things into registers: the address bytes, a byte count, the bus timing and, optionally, a trailing opcode. It then writes a launch word. The launch word carries the first opcode, the number of address cycles and the data direction. In a single pass the sequencer walks the flash pins through the command latch, the address latch, the data transfer and the optional trailing command latch, in that order. It then waits out the write-to-busy interval and watches ready/busy until the device reports ready.

A split operation is issued from one launch. Examples are program followed by confirm, read followed by read-start, and random-out followed by its start byte. The trailing byte has its own enable. Data moves through a byte-wide buffer port: a byte index, a write-data input the block reads for program data, and a write strobe for captured read data. Completion is reported through sticky write-one-to-clear status bits, and a mask turns those bits into an interrupt. A software reset register holds the engine idle.

Register word index on `reg_addr`:
- 0: launch word
- 1: trailing command
- 2: status
- 3: interrupt mask
- 4: byte count
- 5: address bytes 0 to 3
- 6: address bytes 4 to 7
- 7: timing
- 8: soft reset

Top module: `nand_seq`

## Requirements
- R1: Writing the launch word (index 0) with bit 31 set starts an operation. The opcode in bits 7:0 is driven first, with CLE high and one WE# pulse.
- R2: When launch bit 30 is set, the address phase drives (bits 29:27)+1 bytes with ALE high. Bytes are taken low byte first from index 5 and then index 6. When bit 30 is clear there is no address phase.
- R3: When launch bit 26 (read) or bit 25 (write) is set, the data phase moves exactly the byte count from index 4 (bits 15:0). With neither flag set, or a count of zero, no data phase runs.
- R4: Read bytes are captured from IO on the RE# rising edge and written to the buffer at the current byte index, with the IO output enable low. Write bytes come from `buf_wdata` at the current index and are driven while WE# is low.
- R5: When bit 8 of index 1 is set, opcode bits 7:0 of index 1 are latched with CLE after the data phase. Bit 8 and the ECC-autogen bit 30 of index 1 read back as zero once the operation completes. Writing zero clears them.
- R6: Status (index 2) bit 31 is command-done and bit 28 is transfer-done. Transfer-done is set only when a data phase ran. Each bit stays set until a 1 is written to it. `irq` is the OR of status AND mask (index 3).
- R7: After the last strobe the engine waits at least tWB+1 cycles and then samples R/B#. Command-done is set only once R/B# is high.
- R8: A launch written while an operation is pending or running is ignored: no pin activity changes. It sets the sticky error bit, status bit 0, which is cleared by writing 1.
- R9: While bit 0 of index 8 is 1, the engine aborts and stays idle: strobes high, CLE and ALE low, no completion. It accepts launches again once the bit is written back to 0.
- R10: Timing (index 7) fields are: bits 7:0 strobe-low time, 15:8 strobe-high time, 23:16 CLE/ALE setup, 31:24 tWB. A value N lasts N+1 cycles. All fields reset to 0xFF.
- R11: After reset WE# and RE# are high, CLE, ALE and the IO output enable are low, and status and `irq` are zero.
- R12: WE# and RE# are never low together, and CLE and ALE are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked status interrupt |
| buf_idx | output | 16 | Current data-phase byte index |
| buf_wdata | input | 8 | Program byte at `buf_idx` |
| buf_rdata | output | 8 | Captured read byte |
| buf_wr_en | output | 1 | Write `buf_rdata` at `buf_idx` |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | IO bus output value |
| nand_io_oe | output | 1 | IO bus output enable |
| nand_io_in | input | 8 | IO bus input value |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The bench runs several operation shapes through a flash model that logs every WE# latch. These are a five-cycle address with a trailing byte, an opcode-only operation with a nonzero count but no direction flag, and an ID read with one address cycle. A design that miscounts address cycles, or runs a data phase without a direction flag, shows up as a wrong event list. A design that forgets to clear the trailing enable would leave a stale confirm byte on the next operation. Holding R/B# low while a second launch arrives catches a design that completes early or restarts mid-operation. A long tWB setting catches one that samples ready too soon. A soft reset during the busy wait checks that no stale completion appears after release.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DATA, ST_TRAIL, ST_TWB, ST_RB
  } seq_state_e;

  typedef struct packed {
    logic [7:0] t_wb;
    logic [7:0] t_setup;
    logic [7:0] t_high;
    logic [7:0] t_low;
  } timing_t;

  // launch word bit positions (decoded by the sequencer)
  localparam int LB_VALID = 31;
  localparam int LB_AEN   = 30;
  localparam int LB_ACNT  = 27;
  localparam int LB_RD    = 26;
  localparam int LB_WR    = 25;

  // status bit positions
  localparam int SB_CMD  = 31;
  localparam int SB_XFER = 28;
  localparam int SB_ERR  = 0;

  // register word indices
  localparam logic [3:0] RI_LAUNCH = 4'd0;
  localparam logic [3:0] RI_TRAIL  = 4'd1;
  localparam logic [3:0] RI_STAT   = 4'd2;
  localparam logic [3:0] RI_MASK   = 4'd3;
  localparam logic [3:0] RI_LEN    = 4'd4;
  localparam logic [3:0] RI_ALO    = 4'd5;
  localparam logic [3:0] RI_AHI    = 4'd6;
  localparam logic [3:0] RI_TIME   = 4'd7;
  localparam logic [3:0] RI_SRST   = 4'd8;

  function automatic logic [3:0] addr_cycles(input logic en, input logic [2:0] fld);
    return en ? ({1'b0, fld} + 4'd1) : 4'd0;
  endfunction

  function automatic logic has_data(input logic rd, input logic wr, input logic [15:0] n);
    return (rd | wr) && (n != 16'd0);
  endfunction

  function automatic logic is_byte_state(input seq_state_e s);
    return (s == ST_CMD) || (s == ST_ADDR) || (s == ST_DATA) || (s == ST_TRAIL);
  endfunction

endpackage

// File: rtl/nand_strobe.sv
module nand_strobe #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [CW-1:0] t_setup,
  input  logic [CW-1:0] t_low,
  input  logic [CW-1:0] t_high,
  output logic          strobe_low,
  output logic          sample,
  output logic          done
);
  typedef enum logic [1:0] {P_OFF, P_SET, P_LOW, P_HIGH} phase_e;
  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero   = (cnt == '0);
  assign strobe_low = (ph == P_LOW);
  assign sample     = (ph == P_LOW) && cnt_zero;
  assign done       = (ph == P_HIGH) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= P_OFF;
      cnt <= '0;
    end else if (clr) begin
      ph  <= P_OFF;
      cnt <= '0;
    end else begin
      case (ph)
        P_OFF: if (start) begin ph <= P_SET; cnt <= t_setup; end
        P_SET: if (cnt_zero) begin ph <= P_LOW; cnt <= t_low; end
               else cnt <= cnt - 1'b1;
        P_LOW: if (cnt_zero) begin ph <= P_HIGH; cnt <= t_high; end
               else cnt <= cnt - 1'b1;
        default: if (cnt_zero) begin
                   if (start) begin ph <= P_SET; cnt <= t_setup; end
                   else ph <= P_OFF;
                 end else cnt <= cnt - 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             engine_busy,
  input  logic             set_cmd_done,
  input  logic             set_xfer_done,
  input  logic             op_finish,
  output logic             go,
  output logic [31:0]      launch_word,
  output logic             trail_en,
  output logic [7:0]       trail_opc,
  output logic [LEN_W-1:0] xfer_len,
  output logic [63:0]      addr_bytes,
  output logic [31:0]      timing_word,
  output logic             srst,
  output logic             irq,
  output logic             launch_hit,
  output logic             busy_any,
  output logic             st_cmd_done,
  output logic             st_err
);
  logic        trail_ecc;
  logic        st_xfer;
  logic [31:0] mask;
  logic [31:0] stat_vec;
  logic        wr_stat;
  logic        accept;

  assign launch_hit = reg_wr && (reg_addr == RI_LAUNCH) && reg_wdata[LB_VALID];
  assign busy_any   = engine_busy || go;
  assign accept     = launch_hit && !busy_any && !srst;
  assign wr_stat    = reg_wr && (reg_addr == RI_STAT);

  always_comb begin
    stat_vec          = '0;
    stat_vec[SB_CMD]  = st_cmd_done;
    stat_vec[SB_XFER] = st_xfer;
    stat_vec[SB_ERR]  = st_err;
  end

  assign irq = |(stat_vec & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go          <= 1'b0;
      launch_word <= '0;
      trail_en    <= 1'b0;
      trail_ecc   <= 1'b0;
      trail_opc   <= '0;
      xfer_len    <= '0;
      addr_bytes  <= '0;
      timing_word <= 32'hFFFF_FFFF;
      srst        <= 1'b0;
      mask        <= '0;
      st_cmd_done <= 1'b0;
      st_xfer     <= 1'b0;
      st_err      <= 1'b0;
    end else begin
      go <= accept;
      if (accept) launch_word <= reg_wdata;
      if (reg_wr) begin
        case (reg_addr)
          RI_TRAIL: begin
            trail_en  <= reg_wdata[8];
            trail_ecc <= reg_wdata[30];
            trail_opc <= reg_wdata[7:0];
          end
          RI_MASK: mask        <= reg_wdata;
          RI_LEN:  xfer_len    <= reg_wdata[LEN_W-1:0];
          RI_ALO:  addr_bytes[31:0]  <= reg_wdata;
          RI_AHI:  addr_bytes[63:32] <= reg_wdata;
          RI_TIME: timing_word <= reg_wdata;
          RI_SRST: srst        <= reg_wdata[0];
          default: ;
        endcase
      end
      if (op_finish || srst) begin
        trail_en  <= 1'b0;
        trail_ecc <= 1'b0;
      end
      // sticky status: set wins over a same-cycle clear
      if (set_cmd_done) st_cmd_done <= 1'b1;
      else if (wr_stat && reg_wdata[SB_CMD]) st_cmd_done <= 1'b0;
      if (set_xfer_done) st_xfer <= 1'b1;
      else if (wr_stat && reg_wdata[SB_XFER]) st_xfer <= 1'b0;
      if (launch_hit && busy_any) st_err <= 1'b1;
      else if (wr_stat && reg_wdata[SB_ERR]) st_err <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RI_LAUNCH: reg_rdata = launch_word;
      RI_TRAIL:  reg_rdata = {1'b0, trail_ecc, 21'd0, trail_en, trail_opc};
      RI_STAT:   reg_rdata = stat_vec;
      RI_MASK:   reg_rdata = mask;
      RI_LEN:    reg_rdata = 32'(xfer_len);
      RI_ALO:    reg_rdata = addr_bytes[31:0];
      RI_AHI:    reg_rdata = addr_bytes[63:32];
      RI_TIME:   reg_rdata = timing_word;
      RI_SRST:   reg_rdata = {31'd0, srst};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq,
  output logic [LEN_W-1:0] buf_idx,
  input  logic [7:0]       buf_wdata,
  output logic [7:0]       buf_rdata,
  output logic             buf_wr_en,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb_n
);
  localparam int NADDR_MAX = 8;
  localparam int AIW       = $clog2(NADDR_MAX) + 1;

  seq_state_e       state, adv, after_addr, after_data;
  logic             go, srst, engine_busy;
  logic [31:0]      launch_word, timing_word;
  logic             trail_en, trail_opc_unused;
  logic [7:0]       trail_opc;
  logic [LEN_W-1:0] xfer_len;
  logic [63:0]      addr_bytes;
  timing_t          tm;

  // captured operation
  logic [7:0]       op_opc, op_trail;
  logic             op_rd, op_wr, op_trail_en;
  logic [AIW-1:0]   op_naddr;
  logic [LEN_W-1:0] op_len;
  logic [63:0]      op_addr;

  logic [AIW-1:0]   acnt;
  logic [LEN_W-1:0] dcnt;
  logic [7:0]       twb_cnt;

  // named internal events
  logic strobe_start, strobe_low, strobe_sample, byte_done;
  logic rd_phase, wr_phase, set_cmd_done, set_xfer_done;
  logic launch_hit, busy_any, st_cmd_done, st_err;
  logic last_addr, last_data;

  assign trail_opc_unused = 1'b0;
  assign tm = timing_t'(timing_word);
  assign engine_busy = (state != ST_IDLE);

  nand_seq_regs #(.LEN_W(LEN_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .engine_busy, .set_cmd_done, .set_xfer_done, .op_finish(set_cmd_done),
    .go, .launch_word, .trail_en, .trail_opc, .xfer_len, .addr_bytes,
    .timing_word, .srst, .irq, .launch_hit, .busy_any, .st_cmd_done, .st_err
  );

  nand_strobe #(.CW(8)) u_strobe (
    .clk, .rst_n, .clr(srst), .start(strobe_start),
    .t_setup(tm.t_setup), .t_low(tm.t_low), .t_high(tm.t_high),
    .strobe_low, .sample(strobe_sample), .done(byte_done)
  );

  assign last_addr = (acnt + 1'b1) == op_naddr;
  assign last_data = (dcnt + 1'b1) == op_len;

  always_comb begin
    after_data = op_trail_en ? ST_TRAIL : ST_TWB;
    after_addr = has_data(op_rd, op_wr, op_len) ? ST_DATA : after_data;
    case (state)
      ST_CMD:   adv = (op_naddr != '0) ? ST_ADDR : after_addr;
      ST_ADDR:  adv = last_addr ? after_addr : ST_ADDR;
      ST_DATA:  adv = last_data ? after_data : ST_DATA;
      ST_TRAIL: adv = ST_TWB;
      default:  adv = state;
    endcase
  end

  assign strobe_start  = ((state == ST_IDLE) && go && !srst) ||
                         (byte_done && is_byte_state(adv));
  assign rd_phase      = (state == ST_DATA) && op_rd;
  assign wr_phase      = (state == ST_DATA) && !op_rd;
  assign set_cmd_done  = (state == ST_RB) && nand_rb_n && !srst;
  assign set_xfer_done = (state == ST_DATA) && byte_done && last_data && !srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      op_opc      <= '0;
      op_trail    <= '0;
      op_rd       <= 1'b0;
      op_wr       <= 1'b0;
      op_trail_en <= 1'b0;
      op_naddr    <= '0;
      op_len      <= '0;
      op_addr     <= '0;
      acnt        <= '0;
      dcnt        <= '0;
      twb_cnt     <= '0;
    end else if (srst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state       <= ST_CMD;
          op_opc      <= launch_word[7:0];
          op_rd       <= launch_word[LB_RD];
          op_wr       <= launch_word[LB_WR];
          op_naddr    <= addr_cycles(launch_word[LB_AEN], launch_word[LB_ACNT+:3]);
          op_len      <= xfer_len;
          op_addr     <= addr_bytes;
          op_trail_en <= trail_en;
          op_trail    <= trail_opc;
          acnt        <= '0;
          dcnt        <= '0;
        end
        ST_TWB: if (twb_cnt == '0) state <= ST_RB;
                else twb_cnt <= twb_cnt - 1'b1;
        ST_RB:  if (nand_rb_n) state <= ST_IDLE;
        default: if (byte_done) begin
          state <= adv;
          if (state == ST_ADDR) acnt <= acnt + 1'b1;
          if (state == ST_DATA) dcnt <= dcnt + 1'b1;
          if (adv == ST_TWB) twb_cnt <= tm.t_wb;
        end
      endcase
    end
  end

  // read capture at the RE# rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_rdata <= '0;
      buf_wr_en <= 1'b0;
    end else begin
      buf_wr_en <= strobe_sample && rd_phase && !srst;
      if (strobe_sample && rd_phase) buf_rdata <= nand_io_in;
    end
  end

  assign buf_idx    = dcnt;
  assign nand_cle   = (state == ST_CMD) || (state == ST_TRAIL);
  assign nand_ale   = (state == ST_ADDR);
  assign nand_we_n  = !(strobe_low && !rd_phase);
  assign nand_re_n  = !(strobe_low && rd_phase);
  assign nand_io_oe = (state == ST_CMD) || (state == ST_ADDR) ||
                      (state == ST_TRAIL) || wr_phase;

  always_comb begin
    case (state)
      ST_CMD:   nand_io_out = op_opc;
      ST_ADDR:  nand_io_out = op_addr[acnt[2:0]*8 +: 8];
      ST_DATA:  nand_io_out = wr_phase ? buf_wdata : 8'h00;
      ST_TRAIL: nand_io_out = op_trail;
      default:  nand_io_out = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        nand_we_n,
  input logic        nand_re_n,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_io_oe,
  input logic        nand_rb_n,
  input logic        srst,
  input logic        launch_hit,
  input logic        busy_any,
  input logic        st_cmd_done,
  input logic        st_err
);
  logic clr_cmd;
  assign clr_cmd = reg_wr && (reg_addr == 4'd2) && reg_wdata[31];

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R4
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_cmd_done && !clr_cmd |=> st_cmd_done);
  // R8
  busy_launch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_hit && busy_any |=> st_err);
  // R9
  srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> nand_we_n && nand_re_n && !nand_cle && !nand_ale);
  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_cmd_done) |-> $past(nand_rb_n));
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
  .nand_we_n, .nand_re_n, .nand_cle, .nand_ale, .nand_io_oe, .nand_rb_n,
  .srst, .launch_hit, .busy_any, .st_cmd_done, .st_err
);

// File: tb/tb_nand_seq.sv
module tb_nand_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [15:0] buf_idx;
  logic [7:0]  buf_wdata, buf_rdata, nand_io_out, nand_io_in;
  logic        buf_wr_en, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic        nand_rb_n = 1'b1;

  int checks = 0, fails = 0;
  bit finished = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nand_seq dut (.*);

  // flash model: log latched bytes, supply read bytes
  int ev_n = 0;
  logic [1:0] ev_k [0:63];
  logic [7:0] ev_b [0:63];
  int last_we_cyc = 0;
  int rd_cnt = 0;
  logic [7:0] rmem [0:63];

  always @(posedge nand_we_n) if (rst_n && ev_n < 64) begin
    ev_k[ev_n] = nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2);
    ev_b[ev_n] = nand_io_out;
    ev_n = ev_n + 1;
    last_we_cyc = cyc;
  end
  always @(posedge nand_re_n) if (rst_n) rd_cnt = rd_cnt + 1;
  assign nand_io_in = 8'hA0 + rd_cnt[7:0];

  function automatic logic [7:0] wpat(input logic [15:0] i);
    return i[7:0] * 8'd3 + 8'd1;
  endfunction
  assign buf_wdata = wpat(buf_idx);
  always @(posedge clk) if (buf_wr_en) rmem[buf_idx[5:0]] <= buf_rdata;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] s;
    int n = 0;
    s = '0;
    while (!s[31] && n < 5000) begin rd(4'd2, s); n++; end
    chk(s[31], tag, s, 32'h8000_0000);
  endtask

  task automatic chk_ev(input int idx, input logic [1:0] k, input logic [7:0] b, input string tag);
    chk(ev_k[idx] == k && ev_b[idx] == b, tag, {ev_k[idx], ev_b[idx]}, {k, b});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe, "R11 pins idle",
        {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}, 5'b11000);
    rd(4'd2, v); chk(v == 0 && !irq, "R11 status/irq zero", {irq, v}, 0);
    rd(4'd7, v); chk(v == 32'hFFFF_FFFF, "R10 timing reset", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_read_id;
    logic [31:0] v;
    int e0 = ev_n, r0 = rd_cnt;
    wr(4'd4, 32'd5);
    wr(4'd5, 32'h0);
    wr(4'd0, 32'h8400_0090 | (32'd1 << 30));
    wait_done("R1 read id done");
    chk(ev_n - e0 == 2, "R2 id read latch count", ev_n - e0, 2);
    chk_ev(e0, 2'd0, 8'h90, "R1 opcode with CLE");
    chk_ev(e0 + 1, 2'd1, 8'h00, "R2 single address cycle");
    chk(rd_cnt - r0 == 5, "R3 read count", rd_cnt - r0, 5);
    for (int i = 0; i < 5; i++)
      chk(rmem[i] == 8'(8'hA0 + r0 + i), "R4 read capture", rmem[i], 8'hA0 + r0 + i);
    rd(4'd2, v); chk(v[28] && v[31], "R6 both done bits", v, 32'h9000_0000);
    wr(4'd2, 32'h8000_0000);
    rd(4'd2, v); chk(!v[31] && v[28], "R6 w1c only bit31", v, 32'h1000_0000);
    wr(4'd2, 32'h1000_0000);
    rd(4'd2, v); chk(v == 0, "R6 all clear", v, 0);
  endtask

  task automatic t_program;
    logic [31:0] v;
    int e0 = ev_n, r0 = rd_cnt;
    wr(4'd1, 32'h4000_0110);
    wr(4'd4, 32'd4);
    wr(4'd5, 32'h0033_2211);
    wr(4'd0, 32'h8000_0080 | (32'd1 << 30) | (32'd2 << 27) | (32'd1 << 25));
    wait_done("R3 program done");
    chk(ev_n - e0 == 9, "R3 program latch count", ev_n - e0, 9);
    chk_ev(e0, 2'd0, 8'h80, "R1 program opcode");
    chk_ev(e0 + 1, 2'd1, 8'h11, "R2 addr byte0");
    chk_ev(e0 + 2, 2'd1, 8'h22, "R2 addr byte1");
    chk_ev(e0 + 3, 2'd1, 8'h33, "R2 addr byte2");
    for (int i = 0; i < 4; i++) chk_ev(e0 + 4 + i, 2'd2, wpat(16'(i)), "R4 write data");
    chk_ev(e0 + 8, 2'd0, 8'h10, "R5 trailing confirm");
    chk(rd_cnt == r0, "R4 no RE on write", rd_cnt - r0, 0);
    rd(4'd1, v); chk(v == 32'h10, "R5 enable and ecc bit cleared", v, 32'h10);
    wr(4'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_no_data;
    logic [31:0] v;
    int e0 = ev_n;
    wr(4'd4, 32'd4);
    wr(4'd0, 32'h8000_00FF);
    wait_done("R3 opcode only done");
    chk(ev_n - e0 == 1, "R3 no address/data phase", ev_n - e0, 1);
    rd(4'd2, v); chk(!v[28], "R6 no transfer-done without data", v, 32'h8000_0000);
    wr(4'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    int e0 = ev_n;
    nand_rb_n = 1'b0;
    wr(4'd1, 32'h1D0);
    wr(4'd5, 32'h0003_0201);
    wr(4'd0, 32'h8000_0060 | (32'd1 << 30) | (32'd2 << 27));
    repeat (300) @(negedge clk);
    rd(4'd2, v); chk(!v[31], "R7 no done while busy", v, 0);
    wr(4'd0, 32'h8000_00AA);
    repeat (50) @(negedge clk);
    rd(4'd2, v); chk(v[0], "R8 error bit set", v, 1);
    chk(ev_n - e0 == 5, "R8 second launch ignored", ev_n - e0, 5);
    chk_ev(e0 + 4, 2'd0, 8'hD0, "R5 trailing after address");
    nand_rb_n = 1'b1;
    wait_done("R7 done after ready");
    chk(ev_n - e0 == 5, "R8 nothing extra after ready", ev_n - e0, 5);
    wr(4'd2, 32'h0000_0001);
    rd(4'd2, v); chk(!v[0] && v[31], "R8 error w1c", v, 32'h8000_0000);
    wr(4'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_twb;
    int n = 0;
    wr(4'd7, 32'h1401_0101);
    wr(4'd3, 32'h8000_0000);
    wr(4'd0, 32'h8000_00FF);
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    chk(irq, "R6 irq on masked done", irq, 1);
    chk(cyc - last_we_cyc >= 21, "R7 tWB wait", cyc - last_we_cyc, 21);
    wr(4'd3, 32'h0);
    #1 chk(!irq, "R6 mask gates irq", irq, 0);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd7, 32'h0301_0101);
  endtask

  task automatic t_srst;
    logic [31:0] v;
    int e0;
    nand_rb_n = 1'b0;
    wr(4'd0, 32'h8000_0060);
    repeat (40) @(negedge clk);
    wr(4'd8, 32'd1);
    repeat (2) @(negedge clk);
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R9 idle in soft reset",
        {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100);
    e0 = ev_n;
    wr(4'd0, 32'h8000_0070);
    repeat (40) @(negedge clk);
    chk(ev_n == e0, "R9 launch ignored in soft reset", ev_n - e0, 0);
    wr(4'd8, 32'd0);
    nand_rb_n = 1'b1;
    repeat (40) @(negedge clk);
    rd(4'd2, v); chk(!v[31], "R9 no stale completion", v, 0);
    wr(4'd0, 32'h8000_00FF);
    wait_done("R9 resumes after release");
    wr(4'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_addr5;
    int e0 = ev_n, r0 = rd_cnt;
    wr(4'd1, 32'h130);
    wr(4'd4, 32'd3);
    wr(4'd5, 32'h4433_2211);
    wr(4'd6, 32'h0000_0055);
    wr(4'd0, 32'h8400_0000 | (32'd1 << 30) | (32'd4 << 27));
    wait_done("R2 five-cycle read done");
    chk(ev_n - e0 == 7, "R2 five address latches", ev_n - e0, 7);
    for (int i = 0; i < 5; i++) chk_ev(e0 + 1 + i, 2'd1, 8'(8'h11 * (i + 1)), "R2 address order");
    chk_ev(e0 + 6, 2'd0, 8'h30, "R5 read-start after data");
    chk(rd_cnt - r0 == 3, "R3 exact read length", rd_cnt - r0, 3);
    wr(4'd2, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr(4'd7, 32'h0301_0101);
    t_read_id();
    t_program();
    t_no_data();
    t_busy();
    t_twb();
    t_srst();
    t_addr5();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule